// File: doc/BRIEF.md
# Indexed Load Address Generator

This block forms the access address for a load whose offset comes from a register. It takes a base value and an offset value. It passes the offset through a barrel shifter, then adds it to or subtracts it from the base. The addressing mode decides two things: whether the bus sees the modified base or the original base, and whether the modified base is returned for writeback to the base register. For a doubleword access, the block also gives the address of the second word.

The operation is computed in one combinational pass and registered once. A request presented with `valid_i` high appears on the outputs one clock later. The block does not check which shift and size combinations a given encoding would allow. Instead, it applies a fixed rule: only word and unsigned-byte loads may shift their offset. A compact mode restricts the offset to an added value with a small left shift.

Top module: `lag_addr_gen`

## Requirements
- R1: The sum is base plus the shifted offset when `sub_i` is 0 and base minus it when `sub_i` is 1. All arithmetic wraps modulo 2^32.
- R2: In offset mode (`mode_i` = 0, and also 3), `addr_o` is the sum and `wb_en_o` is 0.
- R3: In pre-indexed mode (`mode_i` = 1), `addr_o` is the sum, `wb_en_o` is 1 and `wb_base_o` is the sum.
- R4: In post-indexed mode (`mode_i` = 2), `addr_o` is the unmodified base, `wb_en_o` is 1 and `wb_base_o` is the sum.
- R5: Shift kind 0 is a logical left shift by `shift_amt_i` (0 to 31).
- R6: Shift kind 1 is a logical right shift by `shift_amt_i`. An amount code of 0 means a shift by 32, which gives zero.
- R7: Shift kind 2 is an arithmetic right shift. An amount code of 0 means a shift by 32, which gives 32 copies of bit 31.
- R8: Shift kind 3 rotates right by `shift_amt_i` (1 to 31). An amount code of 0 leaves the offset unrotated.
- R9: Shift kind 4 shifts the offset right by one bit and puts `carry_i` in bit 31. Kinds 5 to 7 act as kind 0.
- R10: `size_i` selects word (0), unsigned byte (1), signed byte (2), unsigned halfword (3), signed halfword (4) or doubleword (5). Only sizes 0 and 1 apply the shift. All other sizes use the offset unshifted.
- R11: For size 5, `pair_o` is 1 and `addr2_o` is `addr_o` plus 4. For every other size, `pair_o` is 0.
- R12: When `compact_i` is 1, `sub_i` is ignored (the offset is added). The shift is a left shift by `shift_amt_i[1:0]`, whatever the shift kind.
- R13: The outputs follow an accepted request by exactly one clock. After reset, and in any cycle without a result, `valid_o` and `wb_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| base_i | input | 32 | Base register value |
| offset_i | input | 32 | Offset register value |
| sub_i | input | 1 | 1 = subtract offset |
| shift_kind_i | input | 3 | Shift kind code |
| shift_amt_i | input | 5 | Shift amount code |
| carry_i | input | 1 | Carry used by rotate-through-carry |
| mode_i | input | 2 | Indexing mode |
| size_i | input | 3 | Access size code |
| compact_i | input | 1 | Compact-encoding restrictions |
| valid_o | output | 1 | Result present |
| addr_o | output | 32 | Access address |
| addr2_o | output | 32 | Second word address |
| pair_o | output | 1 | Doubleword access |
| wb_en_o | output | 1 | Base writeback enable |
| wb_base_o | output | 32 | Updated base value |

## Verification
The assertions check the indexing-mode relations on every cycle. They check that post-indexed results address the original base, that pre-indexed results address the written-back value, and that offset mode never writes back. They also check the fixed 4-byte step between doubleword addresses and that writeback only occurs with a valid result. The values produced by each shift kind, the amount-code corner cases (0 meaning 32, unrotated rotation), the size rule that suppresses shifting, the compact restrictions and wraparound arithmetic are shown only by the bench's scenarios. The bench compares those against an independent bit-by-bit model.

// File: rtl/lag_pkg.sv
package lag_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_kind_e;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2
  } idx_mode_e;

  typedef enum logic [2:0] {
    SZ_WORD  = 3'd0,
    SZ_UBYTE = 3'd1,
    SZ_SBYTE = 3'd2,
    SZ_UHALF = 3'd3,
    SZ_SHALF = 3'd4,
    SZ_DWORD = 3'd5
  } acc_size_e;
endpackage

// File: rtl/lag_shifter.sv
module lag_shifter
  import lag_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [2:0]      kind_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            carry_i,
  input  logic            shift_en_i,
  input  logic            compact_i,
  output logic [XLEN-1:0] val_o
);
  logic [SHW-1:0]    amt_eff;
  logic [2:0]        kind_eff;
  logic [2*XLEN-1:0] rot_dbl;
  logic [XLEN-1:0]   shifted;

  always_comb begin
    kind_eff = compact_i ? SH_LSL : kind_i;
    amt_eff  = compact_i ? {{(SHW-2){1'b0}}, amt_i[1:0]} : amt_i;
  end

  assign rot_dbl = {val_i, val_i} >> amt_eff;

  always_comb begin
    unique case (kind_eff)
      SH_LSR:  shifted = (amt_eff == '0) ? '0 : (val_i >> amt_eff);
      SH_ASR:  shifted = (amt_eff == '0) ? {XLEN{val_i[XLEN-1]}}
                                         : XLEN'($signed(val_i) >>> amt_eff);
      SH_ROR:  shifted = rot_dbl[XLEN-1:0];
      SH_RRX:  shifted = {carry_i, val_i[XLEN-1:1]};
      default: shifted = val_i << amt_eff;
    endcase
  end

  assign val_o = shift_en_i ? shifted : val_i;
endmodule

// File: rtl/lag_adder.sv
module lag_adder #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] operand_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o
);
  logic [XLEN-1:0] opnd_x;

  // subtract as base + ~op + 1, wraps naturally
  assign opnd_x = sub_i ? ~operand_i : operand_i;
  assign sum_o  = base_i + opnd_x + XLEN'(sub_i);
endmodule

// File: rtl/lag_index.sv
module lag_index
  import lag_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned STEP = XLEN / 8
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] sum_i,
  input  logic [1:0]      mode_i,
  input  logic [2:0]      size_i,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] addr2_o,
  output logic            pair_o,
  output logic            wb_en_o,
  output logic [XLEN-1:0] wb_base_o
);
  always_comb begin
    unique case (mode_i)
      IDX_PRE:  begin addr_o = sum_i;  wb_en_o = 1'b1; end
      IDX_POST: begin addr_o = base_i; wb_en_o = 1'b1; end
      default:  begin addr_o = sum_i;  wb_en_o = 1'b0; end
    endcase
  end

  assign wb_base_o = sum_i;
  assign pair_o    = (size_i == SZ_DWORD);
  assign addr2_o   = addr_o + XLEN'(STEP);
endmodule

// File: rtl/lag_addr_gen.sv
module lag_addr_gen
  import lag_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW  = $clog2(XLEN),
  localparam int unsigned STEP = XLEN / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] offset_i,
  input  logic            sub_i,
  input  logic [2:0]      shift_kind_i,
  input  logic [SHW-1:0]  shift_amt_i,
  input  logic            carry_i,
  input  logic [1:0]      mode_i,
  input  logic [2:0]      size_i,
  input  logic            compact_i,
  output logic            valid_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] addr2_o,
  output logic            pair_o,
  output logic            wb_en_o,
  output logic [XLEN-1:0] wb_base_o
);
  logic            shift_en;
  logic            sub_eff;
  logic [XLEN-1:0] operand, sum;
  logic [XLEN-1:0] addr_d, addr2_d, wbb_d;
  logic            pair_d, wb_d;

  // only word and unsigned byte shift the offset
  assign shift_en = (size_i == SZ_WORD) || (size_i == SZ_UBYTE);
  assign sub_eff  = sub_i & ~compact_i;

  lag_shifter #(.XLEN(XLEN)) i_shifter (
    .val_i      (offset_i),
    .kind_i     (shift_kind_i),
    .amt_i      (shift_amt_i),
    .carry_i    (carry_i),
    .shift_en_i (shift_en),
    .compact_i  (compact_i),
    .val_o      (operand)
  );

  lag_adder #(.XLEN(XLEN)) i_adder (
    .base_i    (base_i),
    .operand_i (operand),
    .sub_i     (sub_eff),
    .sum_o     (sum)
  );

  lag_index #(.XLEN(XLEN)) i_index (
    .base_i    (base_i),
    .sum_i     (sum),
    .mode_i    (mode_i),
    .size_i    (size_i),
    .addr_o    (addr_d),
    .addr2_o   (addr2_d),
    .pair_o    (pair_d),
    .wb_en_o   (wb_d),
    .wb_base_o (wbb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      addr_o    <= '0;
      addr2_o   <= '0;
      pair_o    <= 1'b0;
      wb_en_o   <= 1'b0;
      wb_base_o <= '0;
    end else begin
      valid_o <= valid_i;
      wb_en_o <= valid_i & wb_d;
      if (valid_i) begin
        addr_o    <= addr_d;
        addr2_o   <= addr2_d;
        pair_o    <= pair_d;
        wb_base_o <= wbb_d;
      end
    end
  end

  assert_idle_no_wb_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !wb_en_o);

  assert_offset_no_wb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i) && ($past(mode_i) == IDX_OFFSET)) |-> !wb_en_o);

  assert_pre_addr_is_wb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i) && ($past(mode_i) == IDX_PRE))
      |-> (wb_en_o && addr_o == wb_base_o));

  assert_post_addr_is_base_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i) && ($past(mode_i) == IDX_POST))
      |-> (wb_en_o && addr_o == $past(base_i)));

  assert_pair_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && pair_o) |-> (addr2_o - addr_o == XLEN'(STEP)));
endmodule

// File: tb/test_lag_addr_gen.sv
module test_lag_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] base_i = '0, offset_i = '0;
  logic        sub_i = 1'b0, carry_i = 1'b0, compact_i = 1'b0;
  logic [2:0]  kind_i = '0, size_i = '0;
  logic [4:0]  amt_i = '0;
  logic [1:0]  mode_i = '0;
  logic        valid_o, pair_o, wb_en_o;
  logic [31:0] addr_o, addr2_o, wb_base_o;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] addr, addr2, wbb;
    logic        pair, wb;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  lag_addr_gen i_lag_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .base_i(base_i),
    .offset_i(offset_i), .sub_i(sub_i), .shift_kind_i(kind_i),
    .shift_amt_i(amt_i), .carry_i(carry_i), .mode_i(mode_i),
    .size_i(size_i), .compact_i(compact_i), .valid_o(valid_o),
    .addr_o(addr_o), .addr2_o(addr2_o), .pair_o(pair_o),
    .wb_en_o(wb_en_o), .wb_base_o(wb_base_o)
  );

  function automatic logic [31:0] model_shift(logic [31:0] v, logic [2:0] k,
      logic [4:0] a, logic c, logic [2:0] sz, logic cmp);
    logic [31:0] r = v;
    int n;
    if (sz > 3'd1) return v;
    if (cmp) begin k = 3'd0; a = {3'b0, a[1:0]}; end
    n = (a == 0) ? 32 : int'(a);
    case (k)
      3'd1: for (int i = 0; i < n; i++) r = {1'b0, r[31:1]};
      3'd2: for (int i = 0; i < n; i++) r = {r[31], r[31:1]};
      3'd3: for (int i = 0; i < int'(a); i++) r = {r[0], r[31:1]};
      3'd4: r = {c, r[31:1]};
      default: for (int i = 0; i < int'(a); i++) r = {r[30:0], 1'b0};
    endcase
    return r;
  endfunction

  task automatic drive(logic [31:0] b, logic [31:0] o, logic s, logic [2:0] k,
      logic [4:0] a, logic c, logic [1:0] m, logic [2:0] sz, logic cmp, string tag);
    exp_t e;
    logic [31:0] op, sum;
    op  = model_shift(o, k, a, c, sz, cmp);
    sum = (s && !cmp) ? b - op : b + op;
    e.addr  = (m == 2'd2) ? b : sum;
    e.addr2 = e.addr + 32'd4;
    e.wbb   = sum;
    e.wb    = (m == 2'd1) || (m == 2'd2);
    e.pair  = (sz == 3'd5);
    e.tag   = tag;
    sb.push_back(e);
    valid_i = 1'b1; base_i = b; offset_i = o; sub_i = s; kind_i = k;
    amt_i = a; carry_i = c; mode_i = m; size_i = sz; compact_i = cmp;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R13: unexpected result addr=%h, expected none", addr_o);
      end else begin
        e = sb.pop_front();
        if (addr_o !== e.addr || wb_en_o !== e.wb || pair_o !== e.pair ||
            (e.wb && wb_base_o !== e.wbb) || (e.pair && addr2_o !== e.addr2)) begin
          errors++;
          $display("FAIL %s: addr=%h wb=%b wbb=%h pair=%b a2=%h, expected addr=%h wb=%b wbb=%h pair=%b a2=%h",
                   e.tag, addr_o, wb_en_o, wb_base_o, pair_o, addr2_o,
                   e.addr, e.wb, e.wbb, e.pair, e.addr2);
        end
      end
    end
  end

  task automatic check_idle(string tag);
    checks++;
    if (valid_o !== 1'b0 || wb_en_o !== 1'b0) begin
      errors++;
      $display("FAIL %s: valid=%b wb=%b, expected 0 0", tag, valid_o, wb_en_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R13 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R13 idle after reset");
    drive(32'h1000, 32'h20, 0, 3'd0, 5'd0, 0, 2'd0, 3'd0, 0, "R1 R2 add offset");
    drive(32'h1000, 32'h20, 1, 3'd0, 5'd0, 0, 2'd0, 3'd0, 0, "R1 sub");
    drive(32'h10, 32'h20, 1, 3'd0, 5'd0, 0, 2'd0, 3'd0, 0, "R1 wrap under");
    drive(32'hFFFF_FFF0, 32'h20, 0, 3'd0, 5'd0, 0, 2'd1, 3'd0, 0, "R1 R3 wrap pre");
    drive(32'h2000, 32'h8, 0, 3'd0, 5'd2, 0, 2'd1, 3'd0, 0, "R3 pre lsl");
    drive(32'h3000, 32'h8, 1, 3'd0, 5'd3, 0, 2'd2, 3'd0, 0, "R4 post");
    drive(32'h0, 32'h1, 0, 3'd0, 5'd31, 0, 2'd0, 3'd0, 0, "R5 lsl 31");
    drive(32'h0, 32'h8000_0000, 0, 3'd1, 5'd4, 0, 2'd0, 3'd0, 0, "R6 lsr 4");
    drive(32'h100, 32'hFFFF_FFFF, 0, 3'd1, 5'd0, 0, 2'd0, 3'd0, 0, "R6 lsr 32");
    drive(32'h0, 32'h8000_0000, 0, 3'd2, 5'd4, 0, 2'd0, 3'd1, 0, "R7 asr 4");
    drive(32'h0, 32'h8000_0001, 0, 3'd2, 5'd0, 0, 2'd0, 3'd0, 0, "R7 asr 32 neg");
    drive(32'h40, 32'h7000_0001, 0, 3'd2, 5'd0, 0, 2'd0, 3'd0, 0, "R7 asr 32 pos");
    drive(32'h0, 32'h0000_00F1, 0, 3'd3, 5'd4, 0, 2'd0, 3'd0, 0, "R8 ror 4");
    drive(32'h0, 32'h1234_5678, 0, 3'd3, 5'd0, 0, 2'd0, 3'd0, 0, "R8 ror 0");
    drive(32'h0, 32'h0000_0003, 0, 3'd4, 5'd7, 1, 2'd0, 3'd0, 0, "R9 rrx c1");
    drive(32'h0, 32'h0000_0002, 0, 3'd4, 5'd7, 0, 2'd0, 3'd1, 0, "R9 rrx c0");
    drive(32'h0, 32'h0000_0002, 0, 3'd6, 5'd3, 0, 2'd0, 3'd0, 0, "R9 kind 6 as lsl");
    drive(32'h500, 32'h10, 0, 3'd0, 5'd4, 0, 2'd0, 3'd3, 0, "R10 half no shift");
    drive(32'h500, 32'h10, 1, 3'd1, 5'd2, 0, 2'd1, 3'd2, 0, "R10 sbyte no shift");
    drive(32'h500, 32'h10, 0, 3'd3, 5'd4, 0, 2'd2, 3'd4, 0, "R10 shalf no shift");
    drive(32'h800, 32'h8, 0, 3'd0, 5'd2, 0, 2'd1, 3'd5, 0, "R10 R11 dword pre");
    drive(32'hFFFF_FFFC, 32'h0, 0, 3'd0, 5'd0, 0, 2'd2, 3'd5, 0, "R11 dword wrap");
    drive(32'h1000, 32'h3, 1, 3'd1, 5'd6, 0, 2'd0, 3'd0, 1, "R12 compact sub ignored");
    drive(32'h1000, 32'h3, 0, 3'd3, 5'd31, 0, 2'd1, 3'd0, 1, "R12 compact lsl 3");
    drive(32'h1000, 32'h40, 0, 3'd0, 5'd0, 0, 2'd3, 3'd0, 0, "R2 mode 3");
    repeat (3) @(negedge clk);
    check_idle("R13 idle after stream");
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R13: %0d results missing, expected 0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R13: watchdog expired, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule